// File: doc/BRIEF.md
# Classified Hardware Error Aggregator

This block collects one-cycle error pulses from five source blocks on each of several tiles. It sorts every pulse into one of three severity classes: correctable (class code 0), non-fatal (class code 1) and fatal (class code 2). Each tile keeps one sticky 32-bit source register per class. Software clears a bit by writing 1 to it. A per-tile master register shows one summary bit per class and holds an interrupt enable. A device-level register holds one sticky fatal flag per tile.

Correctable and non-fatal errors drive the interrupt line. Fatal errors never drive it. They are meant to be read back from the device fatal register after the system has reset the chip. For that reason, a warm reset leaves every status bit untouched and clears only the enable and the read path. A cold reset clears everything.

Software reaches all registers through a simple port. A write takes effect on the clock edge where `wr_en_i` is high. A read returns data on `rd_data_o` in the cycle after `rd_en_i`.

Top module: `herr_aggregator`

## Requirements
- R1: A pulse on `err_i[(t*3+c)*5+s]` sets one bit in the class-c source register of tile t. The bit position depends on the source s: s=0 sets bit 0, s=1 sets bit 8, s=2 sets bit 12, s=3 sets bit 16 and s=4 sets bit 20. The class-c register sits at byte address t*0x100 + 0x7C - 4*c, so correctable is at 0x7C, non-fatal at 0x78 and fatal at 0x74.
- R2: Bits other than 0, 8, 12, 16 and 20 of a source register always read 0. A register address that is not mapped reads 0. A register of a tile that does not exist reads 0.
- R3: Writing a word to a source register clears exactly the bits where the data is 1. Bits where the data is 0 keep their value.
- R4: If a pulse and a write-1 clear hit the same bit in the same cycle, the bit stays set.
- R5: The master register of tile t sits at t*0x100. Bit 26+c is the OR of all bits of the class-c register. Bit 31 is a read/write interrupt enable. Writes to the other bits are ignored.
- R6: `irq_o` is high when, for at least one tile, the enable is set and the correctable or the non-fatal register is non-zero. Fatal bits alone never raise `irq_o`.
- R7: The device fatal register sits at 0xF80. A fatal pulse on tile t sets bit 4*t+2, and the bit clears on a write of 1. All other bits read 0.
- R8: While `warm_rst_n` is low, all source registers and the device fatal register keep their contents. The enables are cleared, so `irq_o` falls.
- R9: `cold_rst_n` low clears every register, the enables and `rd_data_o`.
- R10: `rd_data_o` shows the addressed register in the cycle after `rd_en_i` is high. It is 0 in any cycle after `rd_en_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous active-low reset that clears all state |
| warm_rst_n | input | 1 | Synchronous active-low reset that clears only non-sticky state |
| err_i | input | NUM_TILES*15 | Error pulses, one per tile, class and source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address of the register |
| wr_data_i | input | 32 | Write data; in status registers a 1 clears the bit |
| rd_data_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Interrupt from correctable and non-fatal errors |

## Verification
The capture tests pulse single sources, and then all five sources together, on different tiles and classes. This separates the mapping from source to bit from the decoding of tile and class addresses, and shows whether reserved bits stay clear. Clear tests write partial masks and all-ones masks, and write a clear in the same cycle as a pulse on the same bit. These separate correct write-1-clear from a plain overwrite or a lost event. The interrupt tests use a state with only fatal bits, then add a correctable bit, and then apply a warm reset. This tells the interrupt class filter apart from the enable and from sticky retention. A final cold reset shows that retention ends there.

// File: rtl/herr_pkg.sv
// Package: shared constants, class codes and the source-to-bit mapping
// for the error aggregator. Assumes 32-bit registers and five sources.
package herr_pkg;
    localparam int REG_W      = 32;
    localparam int NUM_CLASS  = 3;
    localparam int NUM_SRC    = 5;
    localparam int OFS_W      = 8;
    localparam int SUM_LSB    = 26;
    localparam int ENABLE_BIT = 31;
    localparam int FLAG_OFS   = 2;
    localparam int FLAG_STEP  = 4;
    localparam logic [OFS_W-1:0] OFS_MASTER   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_CLASS_HI = 8'h7C;

    typedef enum logic [1:0] {
        CLS_CORR     = 2'd0,
        CLS_NONFATAL = 2'd1,
        CLS_FATAL    = 2'd2
    } err_class_e;

    // Bit position of source s inside a class register.
    function automatic int src_pos(input int s);
        case (s)
            0:       return 0;
            1:       return 8;
            2:       return 12;
            3:       return 16;
            4:       return 20;
            default: return 0;
        endcase
    endfunction

    // Mask of the bits that a source can set.
    function automatic logic [REG_W-1:0] src_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++) m[src_pos(s)] = 1'b1;
        return m;
    endfunction

    // Word offset of class c within a tile region (correctable highest).
    function automatic logic [OFS_W-1:0] class_ofs(input int c);
        return OFS_CLASS_HI - OFS_W'(4 * c);
    endfunction
endpackage

// File: rtl/herr_sticky_reg.sv
// Sticky status register with write-1-to-clear. A set in the same cycle
// as a clear wins. Only cold reset clears it; bits outside MASK stay 0.
module herr_sticky_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         cold_rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // Capture new events, drop cleared bits, keep everything else.
    always_ff @(posedge clk) begin
        if (!cold_rst_n) q_o <= '0;
        else             q_o <= ((q_o & ~clr_i) | set_i) & MASK;
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (|(set_i & MASK)) |=> ((q_o & $past(set_i & MASK)) == $past(set_i & MASK)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (|clr_i) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        1'b1 |=> (($past(q_o) & ~$past(clr_i) & ~q_o) == '0));
endmodule

// File: rtl/herr_tile.sv
// One tile's error state: three sticky class registers, an interrupt
// enable and the class summaries. Assumes err_i holds one-cycle pulses
// with index c*NUM_SRC+s, and that wr_en_i is already qualified for
// this tile.
module herr_tile
    import herr_pkg::*;
(
    input  logic                         clk,
    input  logic                         cold_rst_n,
    input  logic                         warm_rst_n,
    input  logic [NUM_CLASS*NUM_SRC-1:0] err_i,
    input  logic                         wr_en_i,
    input  logic [OFS_W-1:0]             ofs_i,
    input  logic [REG_W-1:0]             wr_data_i,
    output logic [NUM_CLASS*REG_W-1:0]   class_q_o,
    output logic [REG_W-1:0]             master_o,
    output logic                         fatal_evt_o,
    output logic                         irq_o
);
    localparam logic [REG_W-1:0] MASK = src_mask();

    logic [NUM_CLASS-1:0] summary;
    logic                 en_q;

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        logic [REG_W-1:0] set_vec;
        logic [REG_W-1:0] clr_vec;

        // Spread the class pulses onto their register bit positions.
        always_comb begin
            set_vec = '0;
            for (int s = 0; s < NUM_SRC; s++)
                set_vec[src_pos(s)] = err_i[c*NUM_SRC+s];
        end

        // Write data clears bits only when this class register is addressed.
        assign clr_vec = (wr_en_i && ofs_i == class_ofs(c)) ? wr_data_i : '0;

        herr_sticky_reg #(.W(REG_W), .MASK(MASK)) u_stat (
            .clk        (clk),
            .cold_rst_n (cold_rst_n),
            .set_i      (set_vec),
            .clr_i      (clr_vec),
            .q_o        (class_q_o[c*REG_W +: REG_W])
        );

        assign summary[c] = |class_q_o[c*REG_W +: REG_W];
    end

    // Interrupt enable: cleared by either reset, written via the master register.
    always_ff @(posedge clk) begin
        if (!cold_rst_n || !warm_rst_n)            en_q <= 1'b0;
        else if (wr_en_i && ofs_i == OFS_MASTER)   en_q <= wr_data_i[ENABLE_BIT];
    end

    // Master register view: enable on top, class summaries at SUM_LSB.
    always_comb begin
        master_o                              = '0;
        master_o[ENABLE_BIT]                  = en_q;
        master_o[SUM_LSB +: NUM_CLASS]        = summary;
    end

    assign fatal_evt_o = |err_i[CLS_FATAL*NUM_SRC +: NUM_SRC];
    assign irq_o       = en_q & (summary[CLS_CORR] | summary[CLS_NONFATAL]);

    p_fatal_no_irq_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (class_q_o[CLS_CORR*REG_W +: REG_W] == '0 &&
         class_q_o[CLS_NONFATAL*REG_W +: REG_W] == '0) |-> !irq_o);

    p_warm_clears_en_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_rst_n |=> !irq_o);
endmodule

// File: rtl/herr_read_mux.sv
// Read decode: picks the addressed register from the tile and device
// state. Assumes the upper address nibble selects the tile; unmapped
// addresses and absent tiles return zero.
module herr_read_mux
    import herr_pkg::*;
#(
    parameter int NUM_TILES = 2,
    parameter int ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 12'hF80
) (
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [NUM_TILES*NUM_CLASS*REG_W-1:0] class_q_i,
    input  logic [NUM_TILES*REG_W-1:0]           master_i,
    input  logic [REG_W-1:0]                     dev_q_i,
    output logic [REG_W-1:0]                     data_o
);
    localparam int SEL_W = ADDR_W - OFS_W;

    logic [SEL_W-1:0] sel;
    logic [OFS_W-1:0] ofs;

    assign sel = addr_i[ADDR_W-1:OFS_W];
    assign ofs = addr_i[OFS_W-1:0];

    // Address decode across device register, tile masters and class registers.
    always_comb begin
        data_o = '0;
        if (addr_i == DEV_ADDR) begin
            data_o = dev_q_i;
        end else begin
            for (int t = 0; t < NUM_TILES; t++) begin
                if (sel == SEL_W'(t)) begin
                    if (ofs == OFS_MASTER) data_o = master_i[t*REG_W +: REG_W];
                    for (int c = 0; c < NUM_CLASS; c++)
                        if (ofs == class_ofs(c))
                            data_o = class_q_i[(t*NUM_CLASS+c)*REG_W +: REG_W];
                end
            end
        end
    end
endmodule

// File: rtl/herr_aggregator.sv
// Top: per-tile error banks, the device fatal flag register, the
// register port and the combined interrupt. Assumes NUM_TILES <= 7 so
// every flag at 4*t+2 fits in 32 bits, and that err_i carries pulses.
module herr_aggregator
    import herr_pkg::*;
#(
    parameter int NUM_TILES = 2,
    parameter int ADDR_W    = 12
) (
    input  logic                                 clk,
    input  logic                                 cold_rst_n,
    input  logic                                 warm_rst_n,
    input  logic [NUM_TILES*NUM_CLASS*NUM_SRC-1:0] err_i,
    input  logic                                 wr_en_i,
    input  logic                                 rd_en_i,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [REG_W-1:0]                     wr_data_i,
    output logic [REG_W-1:0]                     rd_data_o,
    output logic                                 irq_o
);
    localparam int TILE_ERR_W = NUM_CLASS * NUM_SRC;
    localparam int SEL_W      = ADDR_W - OFS_W;
    localparam logic [ADDR_W-1:0] DEV_ADDR = ADDR_W'(12'hF80);

    // Flag positions used in the device fatal register.
    function automatic logic [REG_W-1:0] dev_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int t = 0; t < NUM_TILES; t++) m[t*FLAG_STEP+FLAG_OFS] = 1'b1;
        return m;
    endfunction

    logic [NUM_TILES*NUM_CLASS*REG_W-1:0] class_q;
    logic [NUM_TILES*REG_W-1:0]           master;
    logic [NUM_TILES-1:0]                 tile_irq;
    logic [NUM_TILES-1:0]                 fatal_evt;
    logic [REG_W-1:0]                     dev_set;
    logic [REG_W-1:0]                     dev_clr;
    logic [REG_W-1:0]                     dev_q;
    logic [REG_W-1:0]                     rd_mux;

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
        logic tile_wr;

        assign tile_wr = wr_en_i && (addr_i[ADDR_W-1:OFS_W] == SEL_W'(t));

        herr_tile u_tile (
            .clk         (clk),
            .cold_rst_n  (cold_rst_n),
            .warm_rst_n  (warm_rst_n),
            .err_i       (err_i[t*TILE_ERR_W +: TILE_ERR_W]),
            .wr_en_i     (tile_wr),
            .ofs_i       (addr_i[OFS_W-1:0]),
            .wr_data_i   (wr_data_i),
            .class_q_o   (class_q[t*NUM_CLASS*REG_W +: NUM_CLASS*REG_W]),
            .master_o    (master[t*REG_W +: REG_W]),
            .fatal_evt_o (fatal_evt[t]),
            .irq_o       (tile_irq[t])
        );
    end

    // Route each tile's fatal event onto its device flag position.
    always_comb begin
        dev_set = '0;
        for (int t = 0; t < NUM_TILES; t++)
            dev_set[t*FLAG_STEP+FLAG_OFS] = fatal_evt[t];
    end

    assign dev_clr = (wr_en_i && addr_i == DEV_ADDR) ? wr_data_i : '0;

    herr_sticky_reg #(.W(REG_W), .MASK(dev_mask())) u_dev (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .set_i      (dev_set),
        .clr_i      (dev_clr),
        .q_o        (dev_q)
    );

    herr_read_mux #(
        .NUM_TILES (NUM_TILES),
        .ADDR_W    (ADDR_W),
        .DEV_ADDR  (DEV_ADDR)
    ) u_rd (
        .addr_i    (addr_i),
        .class_q_i (class_q),
        .master_i  (master),
        .dev_q_i   (dev_q),
        .data_o    (rd_mux)
    );

    // Registered read data: valid one cycle after the strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!cold_rst_n || !warm_rst_n) rd_data_o <= '0;
        else if (rd_en_i)               rd_data_o <= rd_mux;
        else                            rd_data_o <= '0;
    end

    assign irq_o = |tile_irq;

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !rd_en_i |=> (rd_data_o == '0));

    p_dev_flag_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
        fatal_evt[0] |=> dev_q[FLAG_OFS]);
endmodule

// File: tb/sim_herr_aggregator.sv
// Directed bench for the error aggregator: one task per scenario.
module sim_herr_aggregator;
    localparam int NT = 2;
    localparam int EW = NT * 15;

    logic          clk = 1'b0;
    logic          cold_rst_n = 1'b0;
    logic          warm_rst_n = 1'b1;
    logic [EW-1:0] err_i = '0;
    logic          wr_en_i = 1'b0;
    logic          rd_en_i = 1'b0;
    logic [11:0]   addr_i = '0;
    logic [31:0]   wr_data_i = '0;
    logic [31:0]   rd_data_o;
    logic          irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    herr_aggregator #(.NUM_TILES(NT)) u0 (
        .clk (clk), .cold_rst_n (cold_rst_n), .warm_rst_n (warm_rst_n),
        .err_i (err_i), .wr_en_i (wr_en_i), .rd_en_i (rd_en_i),
        .addr_i (addr_i), .wr_data_i (wr_data_i), .rd_data_o (rd_data_o),
        .irq_o (irq_o)
    );

    function automatic int eidx(int t, int c, int s);
        return (t*3 + c)*5 + s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic pulse(int idx);
        @(negedge clk) err_i[idx] = 1'b1;
        @(negedge clk) err_i[idx] = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk) begin wr_en_i = 1'b1; addr_i = a; wr_data_i = d; end
        @(negedge clk) wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk) begin rd_en_i = 1'b1; addr_i = a; end
        @(negedge clk) begin d = rd_data_o; rd_en_i = 1'b0; end
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        rd_chk("R9 reset corr", 12'h07C, 32'h0);
        rd_chk("R9 reset master", 12'h100, 32'h0);
        rd_chk("R9 reset dev", 12'hF80, 32'h0);
        check("R6 reset irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_capture;
        pulse(eidx(0, 0, 0));
        rd_chk("R1 tile0 corr gfx", 12'h07C, 32'h0000_0001);
        pulse(eidx(1, 1, 4));
        rd_chk("R1 tile1 nonfatal mem", 12'h178, 32'h0010_0000);
        rd_chk("R1 tile1 corr untouched", 12'h17C, 32'h0);
        @(negedge clk) for (int s = 0; s < 5; s++) err_i[eidx(0, 1, s)] = 1'b1;
        @(negedge clk) err_i = '0;
        rd_chk("R2 all sources only mapped bits", 12'h078, 32'h0011_1101);
    endtask

    task automatic t_clear;
        wr(12'h078, 32'h0000_1100);
        rd_chk("R3 partial clear", 12'h078, 32'h0011_0001);
        wr(12'h078, 32'hFFFF_FFFF);
        rd_chk("R3 full clear", 12'h078, 32'h0);
        rd_chk("R2 unmapped offset", 12'h040, 32'h0);
        rd_chk("R2 absent tile", 12'h37C, 32'h0);
    endtask

    task automatic t_collide;
        @(negedge clk) begin
            err_i[eidx(1, 0, 2)] = 1'b1;
            wr_en_i = 1'b1; addr_i = 12'h17C; wr_data_i = 32'h0000_1000;
        end
        @(negedge clk) begin err_i = '0; wr_en_i = 1'b0; end
        rd_chk("R4 set beats clear", 12'h17C, 32'h0000_1000);
        wr(12'h17C, 32'h0000_1000);
    endtask

    task automatic t_irq_fatal;
        wr(12'h07C, 32'hFFFF_FFFF);
        wr(12'h178, 32'hFFFF_FFFF);
        pulse(eidx(1, 2, 1));
        rd_chk("R1 tile1 fatal sec", 12'h174, 32'h0000_0100);
        rd_chk("R7 dev flag tile1", 12'hF80, 32'h0000_0040);
        wr(12'h100, 32'hFFFF_FFFF);
        rd_chk("R5 master en plus fatal summary", 12'h100, 32'h9000_0000);
        check("R6 fatal alone no irq", {31'b0, irq_o}, 32'h0);
        pulse(eidx(1, 0, 3));
        check("R6 corr raises irq", {31'b0, irq_o}, 32'h1);
        rd_chk("R5 master summaries", 12'h100, 32'h9400_0000);
        pulse(eidx(0, 2, 3));
        rd_chk("R7 dev flags both", 12'hF80, 32'h0000_0044);
        wr(12'hF80, 32'h0000_0040);
        rd_chk("R7 dev w1c", 12'hF80, 32'h0000_0004);
    endtask

    task automatic t_warm;
        @(negedge clk) warm_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) warm_rst_n = 1'b1;
        check("R8 warm irq low", {31'b0, irq_o}, 32'h0);
        rd_chk("R8 warm keeps corr", 12'h17C, 32'h0001_0000);
        rd_chk("R8 warm clears enable", 12'h100, 32'h1400_0000);
        rd_chk("R8 warm keeps dev", 12'hF80, 32'h0000_0004);
        rd_chk("R8 warm keeps fatal", 12'h074, 32'h0001_0000);
    endtask

    task automatic t_cold;
        @(negedge clk) cold_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) cold_rst_n = 1'b1;
        check("R9 cold rd_data", rd_data_o, 32'h0);
        rd_chk("R9 cold corr", 12'h17C, 32'h0);
        rd_chk("R9 cold fatal", 12'h074, 32'h0);
        rd_chk("R9 cold dev", 12'hF80, 32'h0);
        @(negedge clk);
        check("R10 idle read zero", rd_data_o, 32'h0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1;
        t_reset;
        t_capture;
        t_clear;
        t_collide;
        t_irq_fatal;
        t_warm;
        t_cold;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run;
        end
    end
endmodule